// File: doc/BRIEF.md
# Lockable Pad Attribute Register File

This block is a bank of memory-mapped control registers that keeps one 10-bit attribute word for every chip pad. The pads come in two groups, dedicated and multiplexed, and the size of each group is a parameter. The stored words go straight out to the pad ring on two packed arrays. Software reaches the bank over a simple register bus with a request, a write enable, a word address, 32-bit write data and 32-bit read data.

Every 32-bit register carries three attribute words. Only the bits that the pad technology supports can be stored. A support mask parameter selects them, and the two inversion and open-drain bits are always present. Software can find out which features exist by writing ones to a register and reading the value back.

A clear-only lock bit guards the attribute registers. Once software clears the bit, the attributes cannot change again until the next reset.

Top module: `padattr_regfile`

## Requirements
- R1: The lock register sits at word address 0, and its bit 0 resets to 1. A write to it with data bit 0 = 0 clears the bit. A write to it with data bit 0 = 1 leaves the bit unchanged. It reads back as {31'b0, lock}.
- R2: After the lock bit is cleared it stays 0 until reset, whatever is written to it.
- R3: While the lock bit is 0, a write to any attribute register changes neither the stored attributes nor the pad outputs.
- R4: After reset every attribute word is 0, on the outputs and on readback.
- R5: Pad k of a group sits in register k/3 of that group, in bits [10*(k%3)+9 : 10*(k%3)]. Bits 31:30 read as 0, and so do the slots of the last register that hold no pad.
- R6: Attribute bits 1:0 (bit 0 inversion, bit 1 virtual open drain) always store the value written.
- R7: Attribute bits 9:2 are write-any-read-legal. A bit whose `SupportMask` bit is 0 ignores writes and reads and drives 0. The bit meanings are: bit 2 pull enable, bit 3 pull select (1 = up), bit 4 keeper, bit 5 Schmitt trigger, bit 6 slew (1 = fast), bits 8:7 drive strength, bit 9 reserved. With the default mask 0x0EC, bits 2, 3, 5, 6 and 7 are supported.
- R8: Word addresses 1 to DedRegs hold the dedicated registers, with DedRegs = ceil(NumDed/3). The next MuxRegs addresses hold the multiplexed registers, with MuxRegs = ceil(NumMux/3). Any other address reads as 0 and ignores writes.
- R9: A read request (req_i = 1, we_i = 0) loads rdata_o at the next clock edge. rdata_o keeps that value until the next read request, and its reset value is 0.
- R10: The value read from an attribute register always equals the words being driven to the corresponding pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ded_attr_o | output | NumDed*10 | Dedicated pad attribute words, packed [NumDed-1:0][9:0] |
| mux_attr_o | output | NumMux*10 | Multiplexed pad attribute words, packed [NumMux-1:0][9:0] |

## Verification
The assertions assume that the bus inputs are stable around the clock edge and that a request spans exactly one cycle. They also assume that reset is applied before the first transfer. The stimulus drives every transfer on the falling edge and drops req_i one cycle later. Random addresses cover the mapped range and a few unmapped words just past it, and random data sets every bit, so the masked bits are probed all the time. Clearing the lock is kept for a late directed phase, so that the random writes before it can change state.

// File: rtl/padattr_pkg.sv
package padattr_pkg;
  localparam int BusAddrW = 8;
  localparam int BusDataW = 32;
  localparam int AttrW    = 10;
  localparam int PerReg   = 3;

  typedef struct packed {
    logic                wrCfg;
    logic                rdReq;
    logic                selLock;
    logic                selDed;
    logic                selMux;
    logic [BusAddrW-1:0] regIdx;
  } strobe_t;
endpackage

// File: rtl/padattr_ctrl.sv
module padattr_ctrl
  import padattr_pkg::*;
#(
  parameter int DedRegs = 2,
  parameter int MuxRegs = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [BusAddrW-1:0] addr_i,
  input  logic                wbit0_i,
  output logic                lockQ,
  output strobe_t             stb
);
  localparam logic [BusAddrW-1:0] DedLast = BusAddrW'(DedRegs);
  localparam logic [BusAddrW-1:0] MuxLast = BusAddrW'(DedRegs + MuxRegs);

  logic selLock, selDed, selMux, lockWr;

  always_comb begin
    selLock = (addr_i == '0);
    selDed  = (addr_i >= BusAddrW'(1)) && (addr_i <= DedLast);
    selMux  = (addr_i > DedLast) && (addr_i <= MuxLast);
    lockWr  = req_i && we_i && selLock;

    stb.selLock = selLock;
    stb.selDed  = selDed;
    stb.selMux  = selMux;
    stb.rdReq   = req_i && !we_i;
    stb.wrCfg   = req_i && we_i && lockQ && (selDed || selMux);
    if (selDed)      stb.regIdx = addr_i - BusAddrW'(1);
    else if (selMux) stb.regIdx = addr_i - DedLast - BusAddrW'(1);
    else             stb.regIdx = '0;
  end

  // the lock can only be cleared; reset alone sets it again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lockQ <= 1'b1;
    else if (lockWr && !wbit0_i) lockQ <= 1'b0;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lockQ |=> !lockQ); // R2
  AST_LOCK_SET_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == '0 && wbit0_i) |=> lockQ == $past(lockQ)); // R1
endmodule

// File: rtl/padattr_dp.sv
module padattr_dp
  import padattr_pkg::*;
#(
  parameter int              NumDed    = 4,
  parameter int              NumMux    = 16,
  parameter logic [AttrW-1:0] LegalMask = 10'h0EF
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  strobe_t                               stb,
  input  logic                                  lockQ,
  input  logic [BusDataW-1:0]                   wdata_i,
  output logic [NumDed-1:0][AttrW-1:0]          dedAttr,
  output logic [NumMux-1:0][AttrW-1:0]          muxAttr,
  output logic [BusDataW-1:0]                   rdata_o
);
  localparam int DedRegs = (NumDed + PerReg - 1) / PerReg;
  localparam int MuxRegs = (NumMux + PerReg - 1) / PerReg;

  logic [DedRegs-1:0][BusDataW-1:0] dedWords;
  logic [MuxRegs-1:0][BusDataW-1:0] muxWords;
  logic [BusDataW-1:0]              rdNext;

  for (genvar p = 0; p < NumDed; p++) begin : g_ded
    localparam int RegI = p / PerReg;
    localparam int Slot = p % PerReg;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dedAttr[p] <= '0;
      else if (stb.wrCfg && stb.selDed && stb.regIdx == BusAddrW'(RegI))
        dedAttr[p] <= wdata_i[Slot*AttrW +: AttrW] & LegalMask;
    end
  end

  for (genvar p = 0; p < NumMux; p++) begin : g_mux
    localparam int RegI = p / PerReg;
    localparam int Slot = p % PerReg;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) muxAttr[p] <= '0;
      else if (stb.wrCfg && stb.selMux && stb.regIdx == BusAddrW'(RegI))
        muxAttr[p] <= wdata_i[Slot*AttrW +: AttrW] & LegalMask;
    end
  end

  // readback is assembled from the very flops that drive the pads
  always_comb begin
    dedWords = '0;
    muxWords = '0;
    for (int p = 0; p < NumDed; p++)
      dedWords[p/PerReg][(p%PerReg)*AttrW +: AttrW] = dedAttr[p];
    for (int p = 0; p < NumMux; p++)
      muxWords[p/PerReg][(p%PerReg)*AttrW +: AttrW] = muxAttr[p];
  end

  always_comb begin
    rdNext = '0;
    if (stb.selLock) rdNext = {{(BusDataW-1){1'b0}}, lockQ};
    for (int r = 0; r < DedRegs; r++)
      if (stb.selDed && stb.regIdx == BusAddrW'(r)) rdNext = dedWords[r];
    for (int r = 0; r < MuxRegs; r++)
      if (stb.selMux && stb.regIdx == BusAddrW'(r)) rdNext = muxWords[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (stb.rdReq) rdata_o <= rdNext;
  end

  AST_FROZEN_WHEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lockQ |=> ($stable(dedAttr) && $stable(muxAttr))); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb.rdReq && !stb.selLock && !stb.selDed && !stb.selMux) |=> rdata_o == '0); // R8
  AST_TOP_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BusDataW-1:PerReg*AttrW] == '0); // R5
  AST_LEGAL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dedAttr[0] | muxAttr[0]) & ~LegalMask) == '0); // R7
  AST_BASE_BITS_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb.wrCfg && stb.selDed && stb.regIdx == '0)
      |=> dedAttr[0][1:0] == $past(wdata_i[1:0])); // R6
endmodule

// File: rtl/padattr_regfile.sv
module padattr_regfile
  import padattr_pkg::*;
#(
  parameter int               NumDed      = 4,
  parameter int               NumMux      = 16,
  parameter logic [AttrW-1:0] SupportMask = 10'h0EC
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [BusAddrW-1:0]           addr_i,
  input  logic [BusDataW-1:0]           wdata_i,
  output logic [BusDataW-1:0]           rdata_o,
  output logic [NumDed-1:0][AttrW-1:0]  ded_attr_o,
  output logic [NumMux-1:0][AttrW-1:0]  mux_attr_o
);
  localparam int DedRegs = (NumDed + PerReg - 1) / PerReg;
  localparam int MuxRegs = (NumMux + PerReg - 1) / PerReg;
  localparam logic [AttrW-1:0] LegalMask = SupportMask | AttrW'(3);

  strobe_t stb;
  logic    lockQ;

  padattr_ctrl #(.DedRegs(DedRegs), .MuxRegs(MuxRegs)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wbit0_i(wdata_i[0]), .lockQ(lockQ), .stb(stb)
  );

  padattr_dp #(.NumDed(NumDed), .NumMux(NumMux), .LegalMask(LegalMask)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb(stb), .lockQ(lockQ),
    .wdata_i(wdata_i), .dedAttr(ded_attr_o), .muxAttr(mux_attr_o),
    .rdata_o(rdata_o)
  );
endmodule

// File: tb/padattr_regfile_tb.sv
module padattr_regfile_tb;
  localparam int ClkPeriod = 10;
  localparam int NumDed = 4;
  localparam int NumMux = 16;
  localparam logic [9:0] SupMask = 10'h0EC;
  localparam logic [9:0] Legal = SupMask | 10'h3;
  localparam int DedRegs = 2;
  localparam int MuxRegs = 6;
  localparam int LastAddr = DedRegs + MuxRegs;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NumDed-1:0][9:0] dedOut;
  logic [NumMux-1:0][9:0] muxOut;

  int total = 0, bad = 0;
  logic expLock;
  logic [9:0] expDed [NumDed];
  logic [9:0] expMux [NumMux];

  always #(ClkPeriod/2) clk = ~clk;

  padattr_regfile #(.NumDed(NumDed), .NumMux(NumMux), .SupportMask(SupMask)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ded_attr_o(dedOut), .mux_attr_o(muxOut));

  initial begin
    #(ClkPeriod*150000);
    total++; bad++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] v = '0;
    if (a == 0) v = {31'b0, expLock};
    else if (a <= DedRegs) begin
      for (int s = 0; s < 3; s++)
        if ((a-1)*3+s < NumDed) v[s*10 +: 10] = expDed[(a-1)*3+s];
    end else if (a <= LastAddr) begin
      for (int s = 0; s < 3; s++)
        if ((a-1-DedRegs)*3+s < NumMux) v[s*10 +: 10] = expMux[(a-1-DedRegs)*3+s];
    end
    return v;
  endfunction

  function automatic void modelWrite(int a, logic [31:0] d);
    if (a == 0) begin
      if (!d[0]) expLock = 1'b0;
    end else if (expLock && a <= DedRegs) begin
      for (int s = 0; s < 3; s++)
        if ((a-1)*3+s < NumDed) expDed[(a-1)*3+s] = d[s*10 +: 10] & Legal;
    end else if (expLock && a <= LastAddr) begin
      for (int s = 0; s < 3; s++)
        if ((a-1-DedRegs)*3+s < NumMux) expMux[(a-1-DedRegs)*3+s] = d[s*10 +: 10] & Legal;
    end
  endfunction

  task automatic busWrite(int a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = 8'(a); wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    modelWrite(a, d);
  endtask

  task automatic busRead(int a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = 8'(a);
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic checkReg(string tag, int a);
    logic [31:0] d;
    busRead(a, d);
    chk(tag, d, modelRead(a));
  endtask

  task automatic checkPads(string tag);
    for (int p = 0; p < NumDed; p++) chk(tag, 32'(dedOut[p]), 32'(expDed[p]));
    for (int p = 0; p < NumMux; p++) chk(tag, 32'(muxOut[p]), 32'(expMux[p]));
  endtask

  task automatic doReset();
    rst_n = 0;
    expLock = 1;
    for (int p = 0; p < NumDed; p++) expDed[p] = '0;
    for (int p = 0; p < NumMux; p++) expMux[p] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    doReset();
    // R9 reset value, R4 reset state, R1 lock reset
    chk("R9 rdata reset", rdata, 32'h0);
    checkPads("R4 pads after reset");
    for (int a = 0; a <= LastAddr; a++) checkReg("R4 R1 reset readback", a);

    // R1 writing 1 does nothing
    busWrite(0, 32'hFFFF_FFFF);
    checkReg("R1 lock write one", 0);

    // R7 probe all ones: only legal bits stick
    busWrite(1, 32'hFFFF_FFFF);
    busRead(1, d);
    chk("R7 probe ones", d, {2'b0, Legal, Legal, Legal});
    // R5 leftover slots zero (pad 3 only in reg 2)
    busWrite(2, 32'hFFFF_FFFF);
    busRead(2, d);
    chk("R5 leftover slots", d, {22'b0, Legal});
    // R6 bits 1:0 exact
    busWrite(1, 32'h0000_0002);
    chk("R6 base bits", 32'(dedOut[0]), 32'h2);
    chk("R6 neighbour slot", 32'(dedOut[1]), 32'h0);
    // R8 unmapped
    busWrite(LastAddr + 1, 32'hFFFF_FFFF);
    busRead(LastAddr + 1, d);
    chk("R8 unmapped read", d, 32'h0);
    checkPads("R8 unmapped write dropped");
    // R9 hold after read
    busRead(1, d);
    @(negedge clk);
    chk("R9 rdata holds", rdata, modelRead(1));

    // random unlocked traffic
    for (int i = 0; i < 400; i++) begin
      int a = int'($urandom_range(0, LastAddr + 3));
      logic [31:0] v = $urandom();
      if (a == 0) v[0] = 1'b1;
      if ($urandom_range(0, 1) == 0) busWrite(a, v);
      else checkReg("R5 R7 R8 random read", a);
    end
    checkPads("R10 pads match model");
    for (int a = 1; a <= LastAddr; a++) checkReg("R10 readback equals pads", a);

    // clear lock, then attempt writes
    busWrite(0, 32'h0);
    checkReg("R1 lock cleared", 0);
    for (int i = 0; i < 100; i++) begin
      int a = int'($urandom_range(0, LastAddr + 1));
      busWrite(a, $urandom());
    end
    busWrite(0, 32'h1);
    checkReg("R2 lock stays clear", 0);
    checkPads("R3 pads frozen");
    for (int a = 1; a <= LastAddr; a++) checkReg("R3 regs frozen", a);

    // reset restores everything
    doReset();
    checkReg("R2 lock restored by reset", 0);
    checkPads("R4 pads after second reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule